// File: doc/BRIEF.md
# Timing-Speculative Pipeline Register Stage

This block is one register stage of a pipeline that is clocked faster than its worst-case logic delay allows. Each word is captured twice. The main register takes the early value at the normal clock edge. A shadow register takes the value the logic settles to after a delayed sample. Analog delayed clocking is not built here. The settled value comes in on a separate late-data input, which a testbench or a wrapper drives. If the two captures of a word differ, the stage flags a timing violation and repairs the damage in place. It does not need worst-case margins.

The stage supports two recovery modes. In stall mode it copies the shadow value into the main register and asks the pipeline for a one-cycle stall. The corrected word then leaves the stage one cycle late. In flush mode it drops the bad word and raises a flush request, so that the source replays the word. Upstream and downstream traffic use a valid/ready handshake. A saturating counter records how many violations the stage has detected. Correct detection needs the real path delay to fall between the shadow sample offset and that offset plus one clock period. Outside that window the stage gives no guarantee.

Top module: `tspec_stage`

## Requirements
- R1: While `rst` is high at a rising edge, the stage is cleared. After that edge `out_valid`, `err_pulse`, `stall_req` and `flush_req` are 0, `err_count` is 0 and `in_ready` is 1.
- R2: A word accepted when `in_valid` and `in_ready` are both 1, with `late_data` equal to `in_data`, appears on `out_data` with `out_valid` = 1 in the next cycle, and `err_pulse` stays 0.
- R3: A word accepted with `late_data` different from `in_data` makes `err_pulse` = 1 and `out_valid` = 0 in the cycle right after acceptance.
- R4: In stall mode (`flush_mode` = 0), a detected mismatch raises `stall_req` for exactly that one cycle. In the following cycle `out_valid` is 1 and `out_data` equals the late value.
- R5: `err_pulse` lasts a single cycle for each detected mismatch.
- R6: `in_ready` is 0 during a mismatch cycle. A word the source holds on the input across that cycle is accepted afterwards, unchanged and not lost.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value and `in_ready` is 0, so new input is refused.
- R8: In flush mode (`flush_mode` = 1), a mismatch raises `flush_req` for one cycle and keeps `stall_req` at 0. The bad word is dropped, so `out_valid` is 0 in the next cycle.
- R9: `err_count` goes up by one for each mismatch and stays at 2^CNT_W-1 once it reaches that value.
- R10: A synchronous reset that arrives during a mismatch cycle cancels the pending stall and the restore, and clears the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush_mode | input | 1 | Recovery mode: 0 = stall and restore, 1 = flush and replay |
| in_data | input | WIDTH | Early data, taken by the main register |
| late_data | input | WIDTH | Settled data, taken by the shadow register |
| in_valid | input | 1 | Upstream word valid |
| in_ready | output | 1 | Stage can accept a word |
| out_data | output | WIDTH | Registered data |
| out_valid | output | 1 | Registered data valid |
| out_ready | input | 1 | Downstream can accept |
| err_pulse | output | 1 | Timing violation detected this cycle |
| stall_req | output | 1 | One-cycle stall request (stall mode) |
| flush_req | output | 1 | One-cycle flush request (flush mode) |
| err_count | output | CNT_W | Saturating violation count |

## Verification
Several properties are checked on every cycle. The error pulse lasts one cycle. A stall is followed by a valid output. Input is refused during a mismatch. Output is held under backpressure. A flush never raises a stall and drops the word. The counter never goes down, and reset clears all state. Other behaviour only the bench scenarios can show: that the restored word equals the late value, that a word held upstream comes through intact, that the counter stops at its maximum, and that a reset during a mismatch cancels the pending stall.

// File: rtl/tspec_stage.sv
module tspec_stage #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush_mode,
  input  logic [WIDTH-1:0] in_data,
  input  logic [WIDTH-1:0] late_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             err_pulse,
  output logic             stall_req,
  output logic             flush_req,
  output logic [CNT_W-1:0] err_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [WIDTH-1:0] main_q, shadow_q;
  logic             held_q;
  logic [CNT_W-1:0] cnt_q;
  logic             mismatch, take;

  assign mismatch  = held_q && (main_q != shadow_q);
  assign in_ready  = !mismatch && (!held_q || out_ready);
  assign take      = in_valid && in_ready;
  assign out_data  = main_q;
  assign out_valid = held_q && !mismatch;
  assign err_pulse = mismatch;
  assign stall_req = mismatch && !flush_mode;
  assign flush_req = mismatch && flush_mode;
  assign err_count = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      main_q   <= '0;
      shadow_q <= '0;
      held_q   <= 1'b0;
      cnt_q    <= '0;
    end else if (mismatch) begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (flush_mode) held_q <= 1'b0;
      else            main_q <= shadow_q;
    end else if (take) begin
      main_q   <= in_data;
      shadow_q <= late_data;
      held_q   <= 1'b1;
    end else if (out_ready) begin
      held_q <= 1'b0;
    end
  end
endmodule

module tspec_stage_chk #(
  parameter int WIDTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic [WIDTH-1:0] out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             err_pulse,
  input logic             stall_req,
  input logic             flush_req,
  input logic [CNT_W-1:0] err_count
);
  a_r5_err_single: assert property (@(posedge clk) disable iff (rst)
    err_pulse |=> !err_pulse);
  a_r3_err_no_valid: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !out_valid);
  a_r4_stall_then_valid: assert property (@(posedge clk) disable iff (rst)
    stall_req |=> (out_valid && !stall_req));
  a_r6_refuse_on_err: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> !in_ready);
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r8_flush_no_stall: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> !stall_req);
  a_r8_flush_drops: assert property (@(posedge clk) disable iff (rst)
    flush_req |=> !out_valid);
  a_r9_monotonic: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_count >= $past(err_count)));
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !stall_req && !flush_req && err_count == '0));
endmodule

bind tspec_stage tspec_stage_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_data(out_data),
  .out_valid(out_valid), .out_ready(out_ready), .err_pulse(err_pulse),
  .stall_req(stall_req), .flush_req(flush_req), .err_count(err_count)
);

// File: tb/test_tspec_stage.sv
module test_tspec_stage;
  localparam int W = 8;
  localparam int CW = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 0;
  logic          rst = 1;
  logic          flush_mode = 0;
  logic [W-1:0]  in_data = '0, late_data = '0;
  logic          in_valid = 0, out_ready = 1;
  logic          in_ready, out_valid, err_pulse, stall_req, flush_req;
  logic [W-1:0]  out_data;
  logic [CW-1:0] err_count;

  int n_tests = 0, n_fail = 0, exp_cnt = 0;

  always #10 clk = ~clk;

  tspec_stage #(.WIDTH(W), .CNT_W(CW)) i_tspec_stage (
    .clk(clk), .rst(rst), .flush_mode(flush_mode), .in_data(in_data),
    .late_data(late_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .err_pulse(err_pulse), .stall_req(stall_req), .flush_req(flush_req),
    .err_count(err_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic send(input logic [W-1:0] d, input logic [W-1:0] l);
    in_data = d; late_data = l; in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic t_reset;
    eq("R1 out_valid", out_valid, 0);
    eq("R1 err_pulse", err_pulse, 0);
    eq("R1 stall_req", stall_req, 0);
    eq("R1 err_count", err_count, 0);
    eq("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_clean;
    send(8'hA5, 8'hA5);
    eq("R2 out_valid", out_valid, 1);
    eq("R2 out_data", out_data, 8'hA5);
    eq("R2 err_pulse", err_pulse, 0);
    @(negedge clk);
    eq("R2 drained", out_valid, 0);
  endtask

  task automatic t_stall;
    send(8'h3C, 8'h3D);
    eq("R3 err_pulse", err_pulse, 1);
    eq("R3 out_valid", out_valid, 0);
    eq("R4 stall_req", stall_req, 1);
    eq("R8 no flush in stall mode", flush_req, 0);
    exp_cnt++;
    @(negedge clk);
    eq("R5 err cleared", err_pulse, 0);
    eq("R4 stall cleared", stall_req, 0);
    eq("R4 out_valid", out_valid, 1);
    eq("R4 restored data", out_data, 8'h3D);
    eq("R9 count", err_count, exp_cnt);
    @(negedge clk);
  endtask

  task automatic t_held_upstream;
    send(8'h11, 8'h19);
    exp_cnt++;
    in_data = 8'hC7; late_data = 8'hC7; in_valid = 1;
    eq("R6 in_ready low", in_ready, 0);
    @(negedge clk);
    eq("R6 restored out", out_data, 8'h19);
    eq("R6 in_ready back", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    eq("R6 held word valid", out_valid, 1);
    eq("R6 held word data", out_data, 8'hC7);
    @(negedge clk);
  endtask

  task automatic t_backpressure;
    out_ready = 0;
    send(8'h55, 8'h55);
    eq("R7 valid", out_valid, 1);
    eq("R7 in_ready", in_ready, 0);
    in_data = 8'h77; late_data = 8'h77; in_valid = 1;
    @(negedge clk);
    eq("R7 data held", out_data, 8'h55);
    eq("R7 still refusing", in_ready, 0);
    in_valid = 0; out_ready = 1;
    @(negedge clk);
    eq("R7 drained, 77 refused", out_valid, 0);
  endtask

  task automatic t_flush;
    flush_mode = 1;
    send(8'h10, 8'h30);
    exp_cnt++;
    eq("R8 flush_req", flush_req, 1);
    eq("R8 stall_req", stall_req, 0);
    eq("R8 in_ready", in_ready, 0);
    @(negedge clk);
    eq("R8 dropped", out_valid, 0);
    eq("R8 flush single", flush_req, 0);
    flush_mode = 0;
  endtask

  task automatic t_saturate;
    for (int i = 0; i < CMAX + 3; i++) begin
      send(8'h00, 8'h01);
      @(negedge clk);
      @(negedge clk);
      if (exp_cnt < CMAX) exp_cnt++;
    end
    eq("R9 saturated", err_count, CMAX);
  endtask

  task automatic t_reset_mid;
    send(8'h02, 8'h04);
    eq("R10 stall pending", stall_req, 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    eq("R10 stall cancelled", stall_req, 0);
    eq("R10 no output", out_valid, 0);
    eq("R10 count cleared", err_count, 0);
    eq("R10 in_ready", in_ready, 1);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    t_reset;
    t_clean;
    t_stall;
    t_held_upstream;
    t_backpressure;
    t_flush;
    t_saturate;
    t_reset_mid;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule